// File: doc/BRIEF.md
# Register Dependency Stall Detector

This block sits in front of the register-read stage of a five-stage in-order pipeline with fetch, decode, read, execute and write stages. In every cycle it decides whether the instruction waiting to enter the read stage has to be held back. It holds the instruction back when that instruction would read a general register that an older instruction, still in the execute or write stage, has not yet written. There is no forwarding, so any read-after-write overlap with either of those stages gives a hold.

Three copies of the same decode-to-mask unit run side by side in the same cycle:

- The first copy works on the incoming instruction and gives the set of registers it reads.
- The second and third copies work on the execute-stage and write-stage instructions and give the set of registers each one writes.

Every set is a 32-bit vector in which bit n stands for general register n. Register zero always reads as zero, so a match on bit 0 never causes a hold. The hold output is combinational. The pipeline control uses it to keep the candidate and every stage behind it in place. The three masks are also brought out for debug.

Top module: `dep_stall_detect`

## Requirements
- R1: Register-format instructions have opcode bits [31:26]=0, rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0].
  - funct 0x20–0x27, 0x2A, 0x2B, 0x04, 0x06 and 0x07 read rs and rt and write rd.
  - funct 0x00, 0x02 and 0x03 read only rt and write rd.
- R2: Opcodes 0x08–0x0E read rs and write rt. Opcode 0x0F writes rt and reads nothing. Loads 0x20, 0x21, 0x23, 0x24 and 0x25 read rs and write rt. Loads 0x22 and 0x26 read rs and rt and write rt.
- R3: None of the following write any register.
  - Stores 0x28, 0x29, 0x2A, 0x2B and 0x2E, and branches 0x04 and 0x05, read rs and rt.
  - Branches 0x06 and 0x07 read only rs.
  - Opcode 0 with funct 0x08 reads only rs.
- R4: Opcode 0x02 touches no register. Opcode 0x03 writes register 31. Opcode 0 with funct 0x09 reads rs and writes rd. Opcode 0x01 reads rs. With rt 0x10 or 0x11 it also writes register 31. With rt 0x00 or 0x01 it writes nothing. Any other rt value gives empty masks.
- R5: A stage whose valid input is low gives all-zero masks. An invalid candidate never causes a hold.
- R6: hold_read is 1 exactly when the candidate read mask, with bit 0 cleared, shares a bit with the OR of the execute and write-stage write masks.
- R7: An overlap on register 0 alone never raises hold_read. The debug masks still show bit 0 as decoded.
- R8: Any opcode or funct value not listed here gives empty read and write masks.
- R9: Opcode 0 with funct 0x18–0x1B reads rs and rt. With funct 0x11 or 0x13 it reads rs. With funct 0x10 or 0x12 it writes rd. With funct 0x0C or 0x0D it touches no register. None of these write any other general register.
- R10: hold_read and all three masks follow a change of the inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cand_valid | input | 1 | Candidate for the read stage is present |
| cand_instr | input | 32 | Candidate instruction word |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_instr | input | 32 | Execute-stage instruction word |
| wb_valid | input | 1 | Write stage holds an instruction |
| wb_instr | input | 32 | Write-stage instruction word |
| hold_read | output | 1 | Keep the candidate and the stages behind it in place |
| dbg_cand_src | output | 32 | Registers read by the candidate |
| dbg_ex_dst | output | 32 | Registers written by the execute-stage instruction |
| dbg_wb_dst | output | 32 | Registers written by the write-stage instruction |

## Verification
The hardest case to reach from the ports is an overlap that falls on register 0 and nothing else, while a real write to another register is also present in the pipeline. Purely random words almost never line up like that.

The stimulus therefore draws register fields from a small pool that includes zero. This makes exact collisions, including collisions on register 0 alone, occur often. Directed cases then place a write to $0 in one stage against a read of $0 and of an unrelated register.

Link writes to register 31 are lined up in the same way against candidates that read register 31.

// File: rtl/dep_pkg.sv
// Shared types for the register dependency stall detector.
// Assumes a 32-bit instruction word with the usual R/I/J field layout.
package dep_pkg;

    localparam int INSTR_W = 32;
    localparam int FIELD_W = 5;

    // Which instruction field, if any, names the destination register
    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RD   = 2'd1,
        DST_RT   = 2'd2,
        DST_LINK = 2'd3
    } dst_sel_e;

    // Register usage of one decoded instruction
    typedef struct packed {
        logic     use_rs;
        logic     use_rt;
        dst_sel_e dst;
    } reg_use_t;

    // Major opcodes
    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_REGIMM  = 6'h01;
    localparam logic [5:0] OPC_J       = 6'h02;
    localparam logic [5:0] OPC_JAL     = 6'h03;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_BNE     = 6'h05;
    localparam logic [5:0] OPC_BLEZ    = 6'h06;
    localparam logic [5:0] OPC_BGTZ    = 6'h07;
    localparam logic [5:0] OPC_LUI     = 6'h0F;

    localparam reg_use_t USE_NOTHING = '{use_rs: 1'b0, use_rt: 1'b0, dst: DST_NONE};

endpackage

// File: rtl/dep_decode.sv
// Instruction classifier: turns a raw instruction word into the register
// usage record (source fields read, destination selector).
// Assumes the standard field positions; unlisted encodings use nothing.
module dep_decode
    import dep_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output reg_use_t           usage
);

    logic [5:0] opc;
    logic [5:0] funct;
    logic [4:0] rt_f;

    assign opc   = instr[31:26];
    assign funct = instr[5:0];
    assign rt_f  = instr[20:16];

    // Classify register-format instructions by function code
    function automatic reg_use_t decode_special(input logic [5:0] fn);
        reg_use_t u;
        u = USE_NOTHING;
        unique case (fn)
            6'h00, 6'h02, 6'h03: begin u.use_rt = 1'b1; u.dst = DST_RD; end
            6'h04, 6'h06, 6'h07: begin u.use_rs = 1'b1; u.use_rt = 1'b1; u.dst = DST_RD; end
            6'h08:               begin u.use_rs = 1'b1; end
            6'h09:               begin u.use_rs = 1'b1; u.dst = DST_RD; end
            6'h0C, 6'h0D:        begin u = USE_NOTHING; end
            6'h10, 6'h12:        begin u.dst = DST_RD; end
            6'h11, 6'h13:        begin u.use_rs = 1'b1; end
            6'h18, 6'h19, 6'h1A, 6'h1B:
                                 begin u.use_rs = 1'b1; u.use_rt = 1'b1; end
            6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B:
                                 begin u.use_rs = 1'b1; u.use_rt = 1'b1; u.dst = DST_RD; end
            default:             u = USE_NOTHING;
        endcase
        return u;
    endfunction

    // Classify the register-immediate branch group by its rt sub-code
    function automatic reg_use_t decode_regimm(input logic [4:0] sub);
        reg_use_t u;
        u = USE_NOTHING;
        unique case (sub)
            5'h00, 5'h01: u.use_rs = 1'b1;
            5'h10, 5'h11: begin u.use_rs = 1'b1; u.dst = DST_LINK; end
            default:      u = USE_NOTHING;
        endcase
        return u;
    endfunction

    // Select the register usage for the full opcode space
    always_comb begin
        usage = USE_NOTHING;
        unique case (opc)
            OPC_SPECIAL: usage = decode_special(funct);
            OPC_REGIMM:  usage = decode_regimm(rt_f);
            OPC_J:       usage = USE_NOTHING;
            OPC_JAL:     usage.dst = DST_LINK;
            OPC_BEQ, OPC_BNE: begin usage.use_rs = 1'b1; usage.use_rt = 1'b1; end
            OPC_BLEZ, OPC_BGTZ: usage.use_rs = 1'b1;
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E:
                begin usage.use_rs = 1'b1; usage.dst = DST_RT; end
            OPC_LUI:     usage.dst = DST_RT;
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25:
                begin usage.use_rs = 1'b1; usage.dst = DST_RT; end
            6'h22, 6'h26:
                begin usage.use_rs = 1'b1; usage.use_rt = 1'b1; usage.dst = DST_RT; end
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:
                begin usage.use_rs = 1'b1; usage.use_rt = 1'b1; end
            default:     usage = USE_NOTHING;
        endcase
    end

    // Every source read must be a real field read, never a stray value
    always_comb begin
        if (opc == OPC_J)
            AST_JUMP_USES_NOTHING: assert (usage == USE_NOTHING)
                else $error("plain jump decoded with register use"); // R4
    end

endmodule

// File: rtl/dep_mask_unit.sv
// One dependency unit: decodes an instruction and expands its register usage
// into a one-hot-per-register read mask and write mask.
// Assumes REG_COUNT covers every 5-bit register index. An invalid stage gives
// empty masks.
module dep_mask_unit
    import dep_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int LINK_REG  = 31
) (
    input  logic                 valid,
    input  logic [INSTR_W-1:0]   instr,
    output logic [REG_COUNT-1:0] rd_mask,
    output logic [REG_COUNT-1:0] wr_mask
);

    localparam int IDX_W = $clog2(REG_COUNT);
    localparam logic [REG_COUNT-1:0] ONE = REG_COUNT'(1);

    reg_use_t         usage;
    logic [IDX_W-1:0] rs_idx;
    logic [IDX_W-1:0] rt_idx;
    logic [IDX_W-1:0] rd_idx;

    dep_decode u_decode (
        .instr (instr),
        .usage (usage)
    );

    assign rs_idx = IDX_W'(instr[25:21]);
    assign rt_idx = IDX_W'(instr[20:16]);
    assign rd_idx = IDX_W'(instr[15:11]);

    // Build the set of registers the instruction reads
    always_comb begin
        rd_mask = '0;
        if (valid) begin
            if (usage.use_rs) rd_mask = rd_mask | (ONE << rs_idx);
            if (usage.use_rt) rd_mask = rd_mask | (ONE << rt_idx);
        end
    end

    // Build the set of registers the instruction writes
    always_comb begin
        wr_mask = '0;
        if (valid) begin
            unique case (usage.dst)
                DST_RD:   wr_mask = ONE << rd_idx;
                DST_RT:   wr_mask = ONE << rt_idx;
                DST_LINK: wr_mask = ONE << LINK_REG;
                default:  wr_mask = '0;
            endcase
        end
    end

    // Unit-level guards on the produced masks
    always_comb begin
        if (!valid)
            AST_EMPTY_STAGE_ZERO: assert (rd_mask == '0 && wr_mask == '0)
                else $error("invalid stage produced a mask"); // R5
        AST_SINGLE_DEST: assert ($onehot0(wr_mask))
            else $error("more than one destination register"); // R1
        AST_TWO_SOURCES_MAX: assert ($countones(rd_mask) <= 2)
            else $error("more than two source registers"); // R3
    end

endmodule

// File: rtl/dep_hazard_cmp.sv
// Hazard comparator: intersects the candidate read mask with the union of the
// producer write masks, ignoring the hard-wired zero register.
// Assumes all masks share one register numbering. Purely combinational.
module dep_hazard_cmp #(
    parameter int REG_COUNT = 32,
    parameter int NUM_PROD  = 2,
    parameter int ZERO_REG  = 0
) (
    input  logic [REG_COUNT-1:0]               src_mask,
    input  logic [NUM_PROD-1:0][REG_COUNT-1:0] prod_mask,
    output logic                               stall
);

    localparam logic [REG_COUNT-1:0] ZERO_BIT    = REG_COUNT'(1) << ZERO_REG;
    localparam logic [REG_COUNT-1:0] COMPARE_SET = ~ZERO_BIT;

    logic [REG_COUNT-1:0] pending;
    logic [REG_COUNT-1:0] clash;

    // Merge the write sets of all producer stages
    always_comb begin
        pending = '0;
        for (int p = 0; p < NUM_PROD; p++) begin
            pending = pending | prod_mask[p];
        end
    end

    // Compare and reduce to the hold decision
    assign clash = src_mask & pending & COMPARE_SET;
    assign stall = |clash;

    // Decision guards
    always_comb begin
        if (stall)
            AST_HOLD_NEEDS_WRITER: assert (prod_mask != '0 && src_mask != '0)
                else $error("hold with no producer or no source"); // R6
        if ((src_mask & prod_mask[0]) == ZERO_BIT &&
            (NUM_PROD < 2 || (src_mask & prod_mask[NUM_PROD-1]) == ZERO_BIT))
            AST_ZERO_REG_NO_HOLD: assert (!stall)
                else $error("hold raised by the zero register"); // R7
        if (src_mask == '0)
            AST_NO_SOURCE_NO_HOLD: assert (!stall)
                else $error("hold without any source register"); // R5
    end

endmodule

// File: rtl/dep_stall_detect.sv
// Register dependency stall detector (top).
// Three parallel dependency units: slot 0 decodes the read-stage candidate,
// slot 1 the execute-stage instruction, slot 2 the write-stage instruction.
// The comparator raises hold_read on any read-after-write overlap.
// Assumes no forwarding. The result is combinational within the cycle.
module dep_stall_detect
    import dep_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int LINK_REG  = 31,
    parameter int ZERO_REG  = 0
) (
    input  logic                 cand_valid,
    input  logic [INSTR_W-1:0]   cand_instr,
    input  logic                 ex_valid,
    input  logic [INSTR_W-1:0]   ex_instr,
    input  logic                 wb_valid,
    input  logic [INSTR_W-1:0]   wb_instr,
    output logic                 hold_read,
    output logic [REG_COUNT-1:0] dbg_cand_src,
    output logic [REG_COUNT-1:0] dbg_ex_dst,
    output logic [REG_COUNT-1:0] dbg_wb_dst
);

    localparam int NUM_UNITS = 3;
    localparam int NUM_PROD  = NUM_UNITS - 1;

    logic [NUM_UNITS-1:0]                unit_valid;
    logic [NUM_UNITS-1:0][INSTR_W-1:0]   unit_instr;
    logic [NUM_UNITS-1:0][REG_COUNT-1:0] unit_rd;
    logic [NUM_UNITS-1:0][REG_COUNT-1:0] unit_wr;
    logic [NUM_PROD-1:0][REG_COUNT-1:0]  prod_wr;

    // Gather the stage inputs into unit slots
    assign unit_valid = {wb_valid, ex_valid, cand_valid};
    assign unit_instr = {wb_instr, ex_instr, cand_instr};

    // One dependency unit per observed stage, all evaluated in parallel
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        dep_mask_unit #(
            .REG_COUNT (REG_COUNT),
            .LINK_REG  (LINK_REG)
        ) u_mask (
            .valid   (unit_valid[g]),
            .instr   (unit_instr[g]),
            .rd_mask (unit_rd[g]),
            .wr_mask (unit_wr[g])
        );
    end

    // Producer write sets come from the slots after the candidate
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
        assign prod_wr[p] = unit_wr[p+1];
    end

    dep_hazard_cmp #(
        .REG_COUNT (REG_COUNT),
        .NUM_PROD  (NUM_PROD),
        .ZERO_REG  (ZERO_REG)
    ) u_cmp (
        .src_mask  (unit_rd[0]),
        .prod_mask (prod_wr),
        .stall     (hold_read)
    );

    assign dbg_cand_src = unit_rd[0];
    assign dbg_ex_dst   = unit_wr[1];
    assign dbg_wb_dst   = unit_wr[2];

    // Top-level guards relating ports
    always_comb begin
        if (!cand_valid)
            AST_IDLE_CAND_NO_HOLD: assert (!hold_read)
                else $error("hold with no candidate"); // R5
        if (!ex_valid && !wb_valid)
            AST_EMPTY_PIPE_NO_HOLD: assert (!hold_read)
                else $error("hold with empty producer stages"); // R6
    end

endmodule

// File: tb/tb_dep_stall_detect.sv
module tb_dep_stall_detect;

    localparam time PERIOD = 8ns;

    logic        clk = 1'b0;
    logic        cand_valid, ex_valid, wb_valid;
    logic [31:0] cand_instr, ex_instr, wb_instr;
    logic        hold_read;
    logic [31:0] dbg_cand_src, dbg_ex_dst, dbg_wb_dst;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    dep_stall_detect dut (
        .cand_valid   (cand_valid),
        .cand_instr   (cand_instr),
        .ex_valid     (ex_valid),
        .ex_instr     (ex_instr),
        .wb_valid     (wb_valid),
        .wb_instr     (wb_instr),
        .hold_read    (hold_read),
        .dbg_cand_src (dbg_cand_src),
        .dbg_ex_dst   (dbg_ex_dst),
        .dbg_wb_dst   (dbg_wb_dst)
    );

    function automatic logic [31:0] rt_word(int rs, int rt, int rd, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] it_word(int op, int rs, int rt);
        return {6'(op), 5'(rs), 5'(rt), 16'h1234};
    endfunction

    function automatic logic [31:0] bit_of(int r);
        return 32'h1 << r;
    endfunction

    // Reference register usage written from the requirement text
    function automatic logic [63:0] ref_masks(logic v, logic [31:0] w);
        int op, fn, rs, rt, rd;
        logic [31:0] rdm, wrm;
        op = int'(w[31:26]); fn = int'(w[5:0]);
        rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
        rdm = 0; wrm = 0;
        if (op == 0) begin
            if ((fn >= 'h20 && fn <= 'h27) || fn == 'h2A || fn == 'h2B ||
                fn == 4 || fn == 6 || fn == 7) begin
                rdm = bit_of(rs) | bit_of(rt); wrm = bit_of(rd);
            end else if (fn == 0 || fn == 2 || fn == 3) begin
                rdm = bit_of(rt); wrm = bit_of(rd);
            end else if (fn == 8 || fn == 'h11 || fn == 'h13) rdm = bit_of(rs);
            else if (fn == 9) begin rdm = bit_of(rs); wrm = bit_of(rd); end
            else if (fn == 'h10 || fn == 'h12) wrm = bit_of(rd);
            else if (fn >= 'h18 && fn <= 'h1B) rdm = bit_of(rs) | bit_of(rt);
        end else if (op == 1) begin
            if (rt == 0 || rt == 1) rdm = bit_of(rs);
            else if (rt == 'h10 || rt == 'h11) begin rdm = bit_of(rs); wrm = bit_of(31); end
        end else if (op == 3) wrm = bit_of(31);
        else if (op == 4 || op == 5) rdm = bit_of(rs) | bit_of(rt);
        else if (op == 6 || op == 7) rdm = bit_of(rs);
        else if (op >= 8 && op <= 'h0E) begin rdm = bit_of(rs); wrm = bit_of(rt); end
        else if (op == 'h0F) wrm = bit_of(rt);
        else if (op == 'h20 || op == 'h21 || op == 'h23 || op == 'h24 || op == 'h25) begin
            rdm = bit_of(rs); wrm = bit_of(rt);
        end else if (op == 'h22 || op == 'h26) begin
            rdm = bit_of(rs) | bit_of(rt); wrm = bit_of(rt);
        end else if (op == 'h28 || op == 'h29 || op == 'h2A || op == 'h2B || op == 'h2E)
            rdm = bit_of(rs) | bit_of(rt);
        if (!v) begin rdm = 0; wrm = 0; end
        return {rdm, wrm};
    endfunction

    // Requirement that governs the masks of one word
    function automatic string tag_of(logic v, logic [31:0] w);
        int op, fn;
        op = int'(w[31:26]); fn = int'(w[5:0]);
        if (!v) return "R5";
        if (op == 0) begin
            if (fn == 8) return "R3";
            if (fn == 9) return "R4";
            if (fn == 'h0C || fn == 'h0D || (fn >= 'h10 && fn <= 'h13) ||
                (fn >= 'h18 && fn <= 'h1B)) return "R9";
            if (fn <= 7 || fn >= 'h20) begin
                if (fn == 1 || fn == 5 || (fn >= 'h28 && fn != 'h2A && fn != 'h2B))
                    return "R8";
                return "R1";
            end
            return "R8";
        end
        if (op <= 3) return "R4";
        if (op <= 7) return "R3";
        if (op <= 'h0F) return "R2";
        if (op >= 'h20 && op <= 'h26 && op != 'h27) return "R2";
        if (op == 'h28 || op == 'h29 || op == 'h2A || op == 'h2B || op == 'h2E) return "R3";
        return "R8";
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one set of stage contents at the falling edge and compare
    task automatic apply(string stall_tag, logic cv, logic [31:0] ci, logic ev,
                         logic [31:0] ei, logic wv, logic [31:0] wi);
        logic [63:0] mc, me, mw;
        logic        exp_hold;
        string       t;
        @(negedge clk);
        cand_valid = cv; cand_instr = ci;
        ex_valid   = ev; ex_instr   = ei;
        wb_valid   = wv; wb_instr   = wi;
        #1;
        mc = ref_masks(cv, ci); me = ref_masks(ev, ei); mw = ref_masks(wv, wi);
        exp_hold = |(mc[63:32] & (me[31:0] | mw[31:0]) & 32'hFFFF_FFFE);
        t = stall_tag;
        if (t == "") t = ((mc[63:32] & (me[31:0] | mw[31:0])) == 32'h1) ? "R7" : "R6";
        check(tag_of(cv, ci), "cand read mask", dbg_cand_src, mc[63:32]);
        check(tag_of(ev, ei), "ex write mask",  dbg_ex_dst,   me[31:0]);
        check(tag_of(wv, wi), "wb write mask",  dbg_wb_dst,   mw[31:0]);
        check(t, "hold_read", 32'(hold_read), 32'(exp_hold));
    endtask

    function automatic logic [31:0] rand_word();
        int k, a, b, c;
        k = int'($urandom % 14);
        a = int'($urandom % 6); b = int'($urandom % 6); c = int'($urandom % 6);
        if ($urandom % 5 == 0) a = 31;
        case (k)
            0: return rt_word(a, b, c, 'h20 + int'($urandom % 8));
            1: return rt_word(a, b, c, int'($urandom % 4) == 0 ? 0 : 'h2A);
            2: return it_word(8 + int'($urandom % 7), a, b);
            3: return it_word('h0F, a, b);
            4: return it_word('h23, a, b);
            5: return it_word('h22, a, b);
            6: return it_word('h2B, a, b);
            7: return it_word(4 + int'($urandom % 4), a, b);
            8: return it_word(3, a, b);
            9: return rt_word(a, b, c, 9);
            10: return it_word(1, a, (($urandom % 2) == 0) ? 'h10 : 1);
            11: return rt_word(a, b, c, 'h18 + int'($urandom % 4));
            12: return rt_word(a, b, c, 'h10 + int'($urandom % 4));
            default: return $urandom;
        endcase
    endfunction

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        w = $urandom(32'd2024);
        cand_valid = 0; ex_valid = 0; wb_valid = 0;
        cand_instr = 0; ex_instr = 0; wb_instr = 0;
        repeat (2) @(posedge clk);
        // Idle state: all stages empty
        apply("R5", 0, rt_word(1, 2, 3, 'h20), 0, rt_word(0, 0, 1, 'h20), 0, it_word(8, 0, 2));
        // R6: add reading r5 behind an add writing r5 in execute
        apply("R6", 1, rt_word(5, 6, 7, 'h21), 1, rt_word(1, 2, 5, 'h21), 0, 0);
        // R6: dependency through the write stage only
        apply("R6", 1, it_word('h2B, 9, 4), 0, 0, 1, it_word('h23, 1, 4));
        // R7: write to $0 against a read of $0 and of r2
        apply("R7", 1, rt_word(0, 2, 3, 'h20), 1, rt_word(1, 1, 0, 'h20), 1, it_word(8, 1, 0));
        // R7: same but r2 also pending -> hold
        apply("R6", 1, rt_word(0, 2, 3, 'h20), 1, rt_word(1, 1, 0, 'h20), 1, it_word(8, 1, 2));
        // R4: link write to r31 against jr r31
        apply("R4", 1, rt_word(31, 0, 0, 8), 1, it_word(3, 0, 0), 0, 0);
        // R4: regimm link form from write stage
        apply("R4", 1, it_word(4, 31, 3), 0, 0, 1, it_word(1, 2, 'h11));
        // R3: store in execute writes nothing
        apply("R3", 1, it_word('h23, 4, 8), 1, it_word('h2B, 8, 4), 1, it_word(5, 4, 8));
        // R5: invalid candidate with real overlap
        apply("R5", 0, rt_word(5, 6, 7, 'h20), 1, rt_word(1, 1, 5, 'h20), 1, it_word(8, 1, 6));
        // R5: overlapping producer marked empty
        apply("R5", 1, rt_word(5, 6, 7, 'h20), 0, rt_word(1, 1, 5, 'h20), 0, it_word(8, 1, 6));
        // R8: unused opcode and unused funct
        apply("R8", 1, {6'h3F, 26'h3FF_FFFF}, 1, rt_word(3, 3, 3, 'h3F), 0, 0);
        // R9: mflo writes rd, mult writes nothing
        apply("R9", 1, rt_word(7, 8, 0, 'h18), 1, rt_word(0, 0, 8, 'h12), 1, rt_word(7, 8, 0, 'h19));
        // R10: change execute stage mid-cycle, no clock edge in between
        @(negedge clk);
        cand_valid = 1; cand_instr = rt_word(10, 11, 12, 'h20);
        ex_valid = 1; ex_instr = rt_word(1, 1, 2, 'h20); wb_valid = 0;
        #1 check("R10", "hold_read before change", 32'(hold_read), 32'd0);
        ex_instr = rt_word(1, 1, 11, 'h20);
        #1 check("R10", "hold_read after change", 32'(hold_read), 32'd1);
        check("R10", "ex write mask after change", dbg_ex_dst, 32'h800);
        // Random traffic from a small register pool
        for (int n = 0; n < 3000; n++) begin
            apply("", ($urandom % 8) != 0, rand_word(), ($urandom % 5) != 0, rand_word(),
                  ($urandom % 5) != 0, rand_word());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule